// File: doc/BRIEF.md
# Oversampled Serial Character Receiver with Clocked Mode

This block takes a serial line and turns it into characters. In its asynchronous mode it counts a strobe that runs at sixteen times the bit rate. It checks that a falling edge on the line is a real start bit by sampling it again half a bit later. It then samples each following bit in the middle of its bit period. Characters hold five to eight data bits, sent least significant bit first. A parity bit may follow, and then one stop bit. In its clocked mode the line is sampled on each rising edge of an external bit clock, and exactly eight data bits make up a character, with no framing bits.

Every completed character updates three error flags: framing, parity and overrun. The received character is copied into the data register only when none of these errors is present. When that happens a ready flag is set, and the ready flag clears when the host pulses a read strobe. The host supplies the bit-rate strobe, and this block does not generate the baud rate.

Top module: `srx_top`

## Requirements
- R1: While `rx_en` is 0 no character completes, whatever the line does, and `rx_data` and all flags hold their values.
- R2: In asynchronous mode, a low pulse on `rxd` that has ended before the 8th strobe after the falling edge produces no character. The receiver then waits for the next falling edge.
- R3: In asynchronous mode each bit is sampled every 16 strobes after the start-bit check, least significant bit first. The data length is 5 + `char_len` bits: `char_len` 0 gives 5 bits and 3 gives 8 bits.
- R4: When the data length is less than 8, the unused upper bits of `rx_data` read as 1.
- R5: With `par_en` = 1 one parity bit follows the data. `par_odd` = 0 selects even parity (data plus parity bit have an even number of ones) and 1 selects odd parity. A mismatch sets `err_parity`.
- R6: A stop bit sampled low sets `err_frame`.
- R7: A character with no error loads `rx_data` and sets `data_ready`. A character with any error leaves `rx_data` unchanged.
- R8: A character that completes while `data_ready` is 1 sets `err_overrun` and is discarded, and `data_ready` stays 1.
- R9: A one-cycle `rd_strobe` clears `data_ready` on the next cycle.
- R10: With `sync_mode` = 1, exactly 8 data bits are taken least significant bit first, each on a rising edge of `ext_clk`. There are no start, parity or stop bits, and `err_frame` and `err_parity` read 0 for such characters.
- R11: All three error flags are rewritten at the end of every character, so a clean character clears earlier errors. `frame_done` pulses for one cycle, and the flags are valid in that same cycle.
- R12: After reset `rx_data` is 8'hFF and `data_ready`, `frame_done` and all error flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Receiver enable |
| sync_mode | input | 1 | 1 = external-clock mode, 0 = oversampled mode |
| os_tick | input | 1 | One-cycle strobe at 16x the bit rate |
| char_len | input | 2 | Data length minus 5 (asynchronous mode) |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | 1 = odd parity, 0 = even |
| rxd | input | 1 | Serial data line, idles high |
| ext_clk | input | 1 | External bit clock for clocked mode |
| rd_strobe | input | 1 | Host read of the data register |
| rx_data | output | 8 | Received data register |
| data_ready | output | 1 | Unread character held |
| frame_done | output | 1 | Pulse at the end of each character |
| err_frame | output | 1 | Stop bit was low |
| err_parity | output | 1 | Parity mismatch |
| err_overrun | output | 1 | Character finished while unread data was held |

## Verification
A bit counter that is off by one, or a phase counter that is wrong, shows up on the character it damages. It appears as a shifted value in `rx_data`, or as a false framing or parity flag, at that character's `frame_done`, which comes about half a bit after the stop bit starts. A ready flag in the wrong state shows up at the next character as a missing or false overrun. It also shows up right after a read strobe. A start detector that passes glitches shows up as a `frame_done` pulse that no one expected, within one character time of the glitch.

// File: rtl/srx_pkg.sv
package srx_pkg;
  localparam int DATA_W  = 8;
  localparam int OS_RATE = 16;
  localparam int MIN_LEN = DATA_W - 3;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_DATA  = 3'd2,
    ST_PAR   = 3'd3,
    ST_STOP  = 3'd4
  } rx_state_e;
endpackage

// File: rtl/srx_rst_sync.sv
module srx_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/srx_bit_sync.sv
module srx_bit_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] ff_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) ff_q[i] <= RST_VAL;
          else        ff_q[i] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) ff_q[i] <= RST_VAL;
          else        ff_q[i] <= ff_q[i-1];
        end
      end
    end
  endgenerate

  assign q = ff_q[STAGES-1];
endmodule

// File: rtl/srx_async_eng.sv
module srx_async_eng
  import srx_pkg::*;
#(
  parameter int W  = DATA_W,
  parameter int OS = OS_RATE
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         tick,
  input  logic         rxd_s,
  input  logic [1:0]   len_sel,
  input  logic         par_en,
  input  logic         par_odd,
  output logic         done,
  output logic [W-1:0] data,
  output logic         fe,
  output logic         pe
);
  localparam int CNT_W = $clog2(OS);
  localparam int BIT_W = $clog2(W);
  localparam logic [CNT_W-1:0] HALF = CNT_W'(OS/2 - 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(OS - 1);

  rx_state_e        state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [BIT_W-1:0] bit_q, bit_d;
  logic [W-1:0]     sh_q, sh_d;
  logic             acc_q, acc_d;
  logic             prev_q, prev_d;
  logic             done_q, done_d;
  logic             fe_q, fe_d;
  logic             pe_q, pe_d;
  logic [BIT_W-1:0] last_bit;

  assign last_bit = BIT_W'(MIN_LEN - 1) + BIT_W'(len_sel);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    bit_d   = bit_q;
    sh_d    = sh_q;
    acc_d   = acc_q;
    prev_d  = prev_q;
    done_d  = 1'b0;
    fe_d    = fe_q;
    pe_d    = pe_q;
    if (!en) begin
      state_d = ST_IDLE;
      cnt_d   = '0;
      prev_d  = 1'b0;
    end else if (tick) begin
      unique case (state_q)
        ST_IDLE: begin
          prev_d = rxd_s;
          if (prev_q && !rxd_s) begin
            state_d = ST_START;
            cnt_d   = '0;
          end
        end
        ST_START: begin
          if (cnt_q == HALF) begin
            cnt_d = '0;
            if (!rxd_s) begin
              state_d = ST_DATA;
              bit_d   = '0;
              sh_d    = '1;
              acc_d   = 1'b0;
              pe_d    = 1'b0;
            end else begin
              state_d = ST_IDLE;
              prev_d  = rxd_s;
            end
          end else begin
            cnt_d = cnt_q + CNT_W'(1);
          end
        end
        ST_DATA: begin
          if (cnt_q == FULL) begin
            cnt_d       = '0;
            sh_d[bit_q] = rxd_s;
            acc_d       = acc_q ^ rxd_s;
            if (bit_q == last_bit) state_d = par_en ? ST_PAR : ST_STOP;
            else                   bit_d   = bit_q + BIT_W'(1);
          end else begin
            cnt_d = cnt_q + CNT_W'(1);
          end
        end
        ST_PAR: begin
          if (cnt_q == FULL) begin
            cnt_d   = '0;
            pe_d    = acc_q ^ rxd_s ^ par_odd;
            state_d = ST_STOP;
          end else begin
            cnt_d = cnt_q + CNT_W'(1);
          end
        end
        ST_STOP: begin
          if (cnt_q == FULL) begin
            cnt_d   = '0;
            fe_d    = !rxd_s;
            done_d  = 1'b1;
            prev_d  = rxd_s;
            state_d = ST_IDLE;
          end else begin
            cnt_d = cnt_q + CNT_W'(1);
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      bit_q   <= '0;
      sh_q    <= '1;
      acc_q   <= 1'b0;
      prev_q  <= 1'b0;
      done_q  <= 1'b0;
      fe_q    <= 1'b0;
      pe_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      bit_q   <= bit_d;
      sh_q    <= sh_d;
      acc_q   <= acc_d;
      prev_q  <= prev_d;
      done_q  <= done_d;
      fe_q    <= fe_d;
      pe_q    <= pe_d;
    end
  end

  assign done = done_q;
  assign data = sh_q;
  assign fe   = fe_q;
  assign pe   = pe_q;

  AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (state_q == ST_IDLE) && !done_q); // R1
  AST_GLITCH_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (en && tick && state_q == ST_START && cnt_q == HALF && rxd_s) |=> state_q == ST_IDLE); // R2
  AST_BIT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DATA) |-> bit_q <= last_bit); // R3
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R11
endmodule

// File: rtl/srx_sync_eng.sv
module srx_sync_eng
  import srx_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         eclk_s,
  input  logic         rxd_s,
  output logic         done,
  output logic [W-1:0] data
);
  localparam int BIT_W = $clog2(W);
  localparam logic [BIT_W-1:0] LAST = BIT_W'(W - 1);

  logic             eprev_q;
  logic [BIT_W-1:0] bit_q, bit_d;
  logic [W-1:0]     sh_q, sh_d;
  logic             done_q, done_d;
  logic             rise;

  assign rise = eclk_s && !eprev_q;

  always_comb begin
    bit_d  = bit_q;
    sh_d   = sh_q;
    done_d = 1'b0;
    if (!en) begin
      bit_d = '0;
    end else if (rise) begin
      sh_d[bit_q] = rxd_s;
      if (bit_q == LAST) begin
        bit_d  = '0;
        done_d = 1'b1;
      end else begin
        bit_d = bit_q + BIT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eprev_q <= 1'b0;
      bit_q   <= '0;
      sh_q    <= '1;
      done_q  <= 1'b0;
    end else begin
      eprev_q <= eclk_s;
      bit_q   <= bit_d;
      sh_q    <= sh_d;
      done_q  <= done_d;
    end
  end

  assign done = done_q;
  assign data = sh_q;

  AST_SYNC_IDLE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !done_q && bit_q == '0); // R1
  AST_SYNC_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> $past(eclk_s) && !$past(eprev_q)); // R10
endmodule

// File: rtl/srx_top.sv
module srx_top
  import srx_pkg::*;
#(
  parameter int W          = DATA_W,
  parameter int OS         = OS_RATE,
  parameter int SYNC_DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rx_en,
  input  logic         sync_mode,
  input  logic         os_tick,
  input  logic [1:0]   char_len,
  input  logic         par_en,
  input  logic         par_odd,
  input  logic         rxd,
  input  logic         ext_clk,
  input  logic         rd_strobe,
  output logic [W-1:0] rx_data,
  output logic         data_ready,
  output logic         frame_done,
  output logic         err_frame,
  output logic         err_parity,
  output logic         err_overrun
);
  logic         rst_s_n;
  logic         rxd_s, eclk_s;
  logic         a_done, a_fe, a_pe, s_done;
  logic [W-1:0] a_data, s_data;
  logic         eng_done, res_fe, res_pe;
  logic [W-1:0] res_data;

  logic [W-1:0] data_q, data_d;
  logic         rdy_q, rdy_d;
  logic         fd_q, fd_d;
  logic         fe_q, fe_d;
  logic         pe_q, pe_d;
  logic         ov_q, ov_d;
  logic         src_sync_q, src_sync_d;

  srx_rst_sync #(.STAGES(SYNC_DEPTH)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_s_n));

  srx_bit_sync #(.STAGES(SYNC_DEPTH), .RST_VAL(1'b1)) u_rxd_sync (
    .clk(clk), .rst_n(rst_s_n), .d(rxd), .q(rxd_s));

  srx_bit_sync #(.STAGES(SYNC_DEPTH), .RST_VAL(1'b0)) u_eclk_sync (
    .clk(clk), .rst_n(rst_s_n), .d(ext_clk), .q(eclk_s));

  srx_async_eng #(.W(W), .OS(OS)) u_async (
    .clk(clk), .rst_n(rst_s_n), .en(rx_en && !sync_mode), .tick(os_tick),
    .rxd_s(rxd_s), .len_sel(char_len), .par_en(par_en), .par_odd(par_odd),
    .done(a_done), .data(a_data), .fe(a_fe), .pe(a_pe));

  srx_sync_eng #(.W(W)) u_sync (
    .clk(clk), .rst_n(rst_s_n), .en(rx_en && sync_mode), .eclk_s(eclk_s),
    .rxd_s(rxd_s), .done(s_done), .data(s_data));

  assign eng_done = a_done || s_done;
  assign res_data = s_done ? s_data : a_data;
  assign res_fe   = s_done ? 1'b0 : a_fe;
  assign res_pe   = s_done ? 1'b0 : a_pe;

  always_comb begin
    data_d     = data_q;
    rdy_d      = rdy_q;
    fd_d       = eng_done;
    fe_d       = fe_q;
    pe_d       = pe_q;
    ov_d       = ov_q;
    src_sync_d = src_sync_q;
    if (eng_done) begin
      src_sync_d = s_done;
      fe_d       = res_fe;
      pe_d       = res_pe;
      ov_d       = rdy_q && !rd_strobe;
      if (!res_fe && !res_pe && !(rdy_q && !rd_strobe)) begin
        data_d = res_data;
        rdy_d  = 1'b1;
      end else begin
        rdy_d  = rdy_q && !rd_strobe;
      end
    end else if (rd_strobe) begin
      rdy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      data_q     <= '1;
      rdy_q      <= 1'b0;
      fd_q       <= 1'b0;
      fe_q       <= 1'b0;
      pe_q       <= 1'b0;
      ov_q       <= 1'b0;
      src_sync_q <= 1'b0;
    end else begin
      data_q     <= data_d;
      rdy_q      <= rdy_d;
      fd_q       <= fd_d;
      fe_q       <= fe_d;
      pe_q       <= pe_d;
      ov_q       <= ov_d;
      src_sync_q <= src_sync_d;
    end
  end

  assign rx_data     = data_q;
  assign data_ready  = rdy_q;
  assign frame_done  = fd_q;
  assign err_frame   = fe_q;
  assign err_parity  = pe_q;
  assign err_overrun = ov_q;

  AST_CLEAN_LOADS: assert property (@(posedge clk) disable iff (!rst_s_n)
    (frame_done && !err_frame && !err_parity && !err_overrun) |-> data_ready); // R7
  AST_ERR_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rst_s_n)
    (frame_done && (err_frame || err_parity || err_overrun)) |-> $stable(rx_data)); // R7
  AST_OVERRUN_READY: assert property (@(posedge clk) disable iff (!rst_s_n)
    (frame_done && err_overrun) |-> data_ready); // R8
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_s_n)
    (rd_strobe && !a_done && !s_done) |=> !data_ready); // R9
  AST_SYNC_NO_FRAMING: assert property (@(posedge clk) disable iff (!rst_s_n)
    (frame_done && src_sync_q) |-> !err_frame && !err_parity); // R10
  AST_DATA_ONLY_ON_DONE: assert property (@(posedge clk) disable iff (!rst_s_n)
    !frame_done |-> $stable(rx_data)); // R1
endmodule

// File: tb/srx_top_tb_top.sv
module srx_top_tb_top;
  localparam int BIT_CYC = 64;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_en = 1'b0;
  logic       sync_mode = 1'b0;
  logic       os_tick;
  logic [1:0] char_len = 2'd3;
  logic       par_en = 1'b0;
  logic       par_odd = 1'b0;
  logic       rxd = 1'b1;
  logic       ext_clk = 1'b0;
  logic       rd_strobe = 1'b0;
  logic [7:0] rx_data;
  logic       data_ready, frame_done, err_frame, err_parity, err_overrun;

  typedef struct {
    logic [7:0] d;
    logic       rdy;
    logic       fe;
    logic       pe;
    logic       ov;
    string      req;
  } exp_t;

  exp_t       sb_q[$];
  int         n_chk = 0;
  int         n_bad = 0;
  int         frames_seen = 0;
  int         frames_exp = 0;
  int         cyc = 0;
  logic [1:0] tdiv = 2'd0;
  logic [7:0] m_data = 8'hFF;
  logic       m_rdy = 1'b0;

  always #10 clk = ~clk;

  always_ff @(posedge clk) tdiv <= tdiv + 2'd1;
  assign os_tick = (tdiv == 2'd3);

  srx_top dut_i (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .sync_mode(sync_mode),
    .os_tick(os_tick), .char_len(char_len), .par_en(par_en), .par_odd(par_odd),
    .rxd(rxd), .ext_clk(ext_clk), .rd_strobe(rd_strobe), .rx_data(rx_data),
    .data_ready(data_ready), .frame_done(frame_done), .err_frame(err_frame),
    .err_parity(err_parity), .err_overrun(err_overrun));

  task automatic check(input logic ok, input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Bench model: decides flags and register contents for one character.
  task automatic expect_char(input logic [7:0] val, input logic fe, input logic pe,
                             input string req);
    exp_t e;
    logic ov;
    ov = m_rdy;
    if (!fe && !pe && !ov) begin
      m_data = val;
      m_rdy  = 1'b1;
    end
    e.d = m_data; e.rdy = m_rdy; e.fe = fe; e.pe = pe; e.ov = ov; e.req = req;
    sb_q.push_back(e);
    frames_exp++;
  endtask

  task automatic line_bit(input logic b);
    rxd = b;
    repeat (BIT_CYC) @(negedge clk);
  endtask

  task automatic send_async(input logic [7:0] d, input int len, input logic pen,
                            input logic podd, input logic bad_par, input logic stop_v,
                            input logic expect_it, input string req);
    logic [7:0] mask, val;
    logic       pbit;
    mask = 8'(16'hFF >> (8 - len));
    val  = (d & mask) | ~mask;
    pbit = (^(d & mask)) ^ podd ^ bad_par;
    @(negedge clk);
    char_len = 2'(len - 5);
    par_en   = pen;
    par_odd  = podd;
    if (expect_it) expect_char(val, !stop_v, pen && bad_par, req);
    line_bit(1'b0);
    for (int i = 0; i < len; i++) line_bit(d[i]);
    if (pen) line_bit(pbit);
    line_bit(stop_v);
    line_bit(1'b1);
    line_bit(1'b1);
  endtask

  task automatic send_sync(input logic [7:0] d, input string req);
    expect_char(d, 1'b0, 1'b0, req);
    for (int i = 0; i < 8; i++) begin
      rxd = d[i];
      repeat (8) @(negedge clk);
      ext_clk = 1'b1;
      repeat (8) @(negedge clk);
      ext_clk = 1'b0;
    end
    repeat (16) @(negedge clk);
  endtask

  task automatic do_read(input string req);
    @(negedge clk);
    rd_strobe = 1'b1;
    @(negedge clk);
    rd_strobe = 1'b0;
    m_rdy = 1'b0;
    check(data_ready == 1'b0, req, "data_ready after read", 8'(data_ready), 8'h00);
  endtask

  // Monitor: pops the scoreboard on every frame_done.
  always @(negedge clk) begin
    if (rst_n && frame_done) begin
      frames_seen++;
      if (sb_q.size() == 0) begin
        check(1'b0, "R1/R2", "unexpected frame_done", 8'h01, 8'h00);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        check(rx_data == e.d, e.req, "rx_data", rx_data, e.d);
        check(data_ready == e.rdy, e.req, "data_ready", 8'(data_ready), 8'(e.rdy));
        check(err_frame == e.fe, "R6", "err_frame", 8'(err_frame), 8'(e.fe));
        check(err_parity == e.pe, "R5", "err_parity", 8'(err_parity), 8'(e.pe));
        check(err_overrun == e.ov, "R8", "err_overrun", 8'(err_overrun), 8'(e.ov));
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      check(1'b0, "R11", "watchdog expired", 8'h00, 8'h01);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] hold;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // R12 reset state
    check(rx_data == 8'hFF, "R12", "rx_data reset", rx_data, 8'hFF);
    check({data_ready, frame_done, err_frame, err_parity, err_overrun} == 5'b0,
          "R12", "flags reset", 8'({data_ready, frame_done, err_frame, err_parity, err_overrun}), 8'h00);
    rx_en = 1'b1;
    repeat (BIT_CYC) @(negedge clk);

    send_async(8'hA5, 8, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, "R3");
    do_read("R9");
    send_async(8'h13, 5, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, "R4");
    do_read("R9");
    send_async(8'h2C, 6, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, "R4");
    do_read("R9");
    send_async(8'h55, 7, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, "R5");
    do_read("R9");
    send_async(8'h29, 6, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, "R5");
    do_read("R9");
    send_async(8'hC3, 8, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, "R5_bad_parity_R7");
    send_async(8'h0F, 8, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, "R5_odd_bad_R7");
    send_async(8'h5A, 8, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R6_R7");
    send_async(8'h81, 8, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, "R11_clean");
    send_async(8'h7E, 8, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, "R8");
    do_read("R9");

    // R2: short low pulse must not start a character
    @(negedge clk);
    rxd = 1'b0;
    repeat (16) @(negedge clk);
    rxd = 1'b1;
    repeat (BIT_CYC * 12) @(negedge clk);
    check(frames_seen == frames_exp, "R2", "frame count after glitch", 8'(frames_seen), 8'(frames_exp));

    // R1: disabled receiver ignores a full character
    hold = rx_data;
    rx_en = 1'b0;
    send_async(8'h3C, 8, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R1");
    check(frames_seen == frames_exp, "R1", "frame count while disabled", 8'(frames_seen), 8'(frames_exp));
    check(rx_data == hold, "R1", "rx_data while disabled", rx_data, hold);
    check(data_ready == 1'b0, "R1", "data_ready while disabled", 8'(data_ready), 8'h00);
    rx_en = 1'b1;
    repeat (BIT_CYC) @(negedge clk);
    send_async(8'h96, 7, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, "R3_after_enable");
    do_read("R9");

    // R10: external-clock mode
    @(negedge clk);
    sync_mode = 1'b1;
    repeat (4) @(negedge clk);
    send_sync(8'h3C, "R10");
    send_sync(8'hE1, "R10_R8");
    do_read("R9");
    send_sync(8'h42, "R10");
    do_read("R9");
    sync_mode = 1'b0;
    rxd = 1'b1;
    repeat (BIT_CYC * 2) @(negedge clk);
    send_async(8'hB7, 8, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, "R11");

    repeat (BIT_CYC) @(negedge clk);
    check(sb_q.size() == 0, "R11", "all characters seen", 8'(sb_q.size()), 8'h00);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule